// File: doc/BRIEF.md
# Byte-Lane Register Bus Adapter

This block is the slave front end of a bank of 16-bit registers placed at even byte addresses. A master presents one request at a time, made of a write flag, a two-bit size code, a byte address and 16 bits of write data, and holds it until the block raises a one-cycle acknowledge. The block steers the data onto the correct byte lanes of the bank, using a separate write enable for each byte, and returns read data on the same 16-bit bus.

Lanes are big-endian. The byte at an even address travels on bus bits [15:8] and lives in bits [15:8] of its location. The byte at an odd address travels on bits [7:0] and lives in bits [7:0]. A 16-bit request at an odd byte address is split into two internal cycles. The first handles the odd byte of location N and the second handles the even byte of location N+1. The master sees a single acknowledge, carrying the merged data for a read. Above the last location the split wraps to location 0.

Top module: `regbus_lane_adapter`

## Requirements
- R1: After reset, req_ack is low, req_rdata is zero and every location reads back as 16'h0000.
- R2: A write with size code 2'b01 and address bit 0 clear loads bits [15:8] of the addressed location from req_wdata[15:8] and leaves bits [7:0] unchanged.
- R3: A write with size code 2'b01 and address bit 0 set loads bits [7:0] of the addressed location from req_wdata[7:0] and leaves bits [15:8] unchanged.
- R4: A read with size code 2'b01 returns the whole 16-bit location on req_rdata, whatever the value of address bit 0.
- R5: A request with size code 2'b10 and address bit 0 clear reads or writes all 16 bits of one location. req_ack is visible after the second rising edge at which req_valid is high. The same timing holds for every request that is not split.
- R6: A write with size code 2'b10 and address bit 0 set stores req_wdata[15:8] into bits [7:0] of location N, the address divided by two. It stores req_wdata[7:0] into bits [15:8] of location N+1. All other bytes keep their values.
- R7: A read with size code 2'b10 and address bit 0 set returns {location N bits [7:0], location N+1 bits [15:8]}. req_ack is visible only after the third rising edge at which req_valid is high.
- R8: When a split access starts at the last location, its second cycle uses location 0.
- R9: Size codes 2'b00 and 2'b11 are acknowledged with the normal timing, change no location and return zero read data.
- R10: req_ack is high for exactly one cycle per request, and req_rdata is zero whenever req_ack is low.
- R11: The acknowledge of any write returns zero on req_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until acknowledge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 01 byte, 10 half-word, others unsupported |
| req_addr | input | ADDR_W | Byte address; bit 0 selects the odd byte |
| req_wdata | input | 16 | Write data, even byte on [15:8] |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with req_ack |

## Verification
In a split write, two functions act within the same access. The first internal cycle writes the low byte of location N, and the second cycle writes the high byte of the next location, which wraps to location 0 when N is the last one. Both writes must leave the neighbouring byte of each location unchanged. The bench provokes this by issuing a split write at every odd address, including the topmost, over a bank whose every byte holds a distinct value. After each access it reads every location back with aligned reads and compares it against an arithmetic model. A write to the wrong location or lane, or a missed wrap, shows up as a mismatch in a location that should not have moved.

// File: rtl/regbus_lane_pkg.sv
package regbus_lane_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND,
        PH_ACK
    } phase_e;

    typedef struct packed {
        logic              we_hi;
        logic              we_lo;
        logic [DATA_W-1:0] data;
    } lane_cmd_t;

    localparam lane_cmd_t LANE_IDLE = '{we_hi: 1'b0, we_lo: 1'b0, data: '0};

    function automatic logic is_split(size_e sz, logic odd);
        return (sz == SZ_HALF) && odd;
    endfunction

    // Lane command for the first (or only) internal cycle.
    function automatic lane_cmd_t first_cmd(logic wr, size_e sz, logic odd,
                                            logic [DATA_W-1:0] wd);
        lane_cmd_t c;
        c = LANE_IDLE;
        if (wr) begin
            unique case (sz)
                SZ_BYTE: begin
                    c.we_hi = !odd;
                    c.we_lo = odd;
                    c.data  = wd;
                end
                SZ_HALF: begin
                    if (odd) begin
                        c.we_lo = 1'b1;
                        c.data  = {8'h00, wd[15:8]};
                    end else begin
                        c.we_hi = 1'b1;
                        c.we_lo = 1'b1;
                        c.data  = wd;
                    end
                end
                default: c = LANE_IDLE;
            endcase
        end
        return c;
    endfunction

    // Lane command for the second cycle of a split access.
    function automatic lane_cmd_t second_cmd(logic wr, logic [DATA_W-1:0] wd);
        lane_cmd_t c;
        c       = LANE_IDLE;
        c.we_hi = wr;
        c.data  = {wd[7:0], 8'h00};
        return c;
    endfunction

    // Read data captured in the first (or only) internal cycle.
    function automatic logic [DATA_W-1:0] first_rd(size_e sz, logic odd,
                                                   logic [DATA_W-1:0] word);
        logic [DATA_W-1:0] r;
        unique case (sz)
            SZ_BYTE: r = word;
            SZ_HALF: r = odd ? {word[7:0], 8'h00} : word;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/regbus_lane_bank.sv
module regbus_lane_bank #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we_hi,
    input  logic                               we_lo,
    input  logic [IDX_W-1:0]                   idx,
    input  logic [regbus_lane_pkg::DATA_W-1:0] wdata,
    output logic [regbus_lane_pkg::DATA_W-1:0] rword
);
    import regbus_lane_pkg::*;

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_loc
        logic sel;
        assign sel = (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else begin
                if (sel && we_hi) mem[g][15:8] <= wdata[15:8];
                if (sel && we_lo) mem[g][7:0]  <= wdata[7:0];
            end
        end
    end

    always_comb begin
        rword = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) rword = mem[i];
        end
    end

endmodule

// File: rtl/regbus_lane_seq.sv
module regbus_lane_seq #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    parameter int ADDR_W   = IDX_W + 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic [1:0]                         req_size,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [regbus_lane_pkg::DATA_W-1:0] req_wdata,
    output logic                               req_ack,
    output logic [regbus_lane_pkg::DATA_W-1:0] req_rdata,
    output logic                               bank_we_hi,
    output logic                               bank_we_lo,
    output logic [IDX_W-1:0]                   bank_idx,
    output logic [regbus_lane_pkg::DATA_W-1:0] bank_wdata,
    input  logic [regbus_lane_pkg::DATA_W-1:0] bank_rword
);
    import regbus_lane_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    phase_e            ph_q;
    logic              wr_q;
    size_e             sz_q;
    logic              odd_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] hold_q;
    logic [IDX_W-1:0]  idx_next;
    lane_cmd_t         cmd;

    assign idx_next = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            wr_q   <= 1'b0;
            sz_q   <= SZ_NONE;
            odd_q  <= 1'b0;
            idx_q  <= '0;
            wd_q   <= '0;
            hold_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        wr_q   <= req_write;
                        sz_q   <= size_e'(req_size);
                        odd_q  <= req_addr[0];
                        idx_q  <= req_addr[ADDR_W-1:1];
                        wd_q   <= req_wdata;
                        hold_q <= '0;
                        ph_q   <= PH_FIRST;
                    end
                end
                PH_FIRST: begin
                    if (!wr_q) hold_q <= first_rd(sz_q, odd_q, bank_rword);
                    ph_q <= is_split(sz_q, odd_q) ? PH_SECOND : PH_ACK;
                end
                PH_SECOND: begin
                    if (!wr_q) hold_q[7:0] <= bank_rword[15:8];
                    ph_q <= PH_ACK;
                end
                default: begin
                    ph_q <= PH_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        unique case (ph_q)
            PH_FIRST:  cmd = first_cmd(wr_q, sz_q, odd_q, wd_q);
            PH_SECOND: cmd = second_cmd(wr_q, wd_q);
            default:   cmd = LANE_IDLE;
        endcase
    end

    assign bank_idx   = (ph_q == PH_SECOND) ? idx_next : idx_q;
    assign bank_we_hi = cmd.we_hi;
    assign bank_we_lo = cmd.we_lo;
    assign bank_wdata = cmd.data;

    assign req_ack   = (ph_q == PH_ACK);
    assign req_rdata = req_ack ? hold_q : '0;

endmodule

// File: rtl/regbus_lane_adapter.sv
module regbus_lane_adapter #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = ((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_ack,
    output logic [15:0]       req_rdata
);
    import regbus_lane_pkg::*;

    localparam int IDX_W = ADDR_W - 1;

    logic              we_hi;
    logic              we_lo;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rword;

    regbus_lane_seq #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ack    (req_ack),
        .req_rdata  (req_rdata),
        .bank_we_hi (we_hi),
        .bank_we_lo (we_lo),
        .bank_idx   (idx),
        .bank_wdata (wdata),
        .bank_rword (rword)
    );

    regbus_lane_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we_hi (we_hi),
        .we_lo (we_lo),
        .idx   (idx),
        .wdata (wdata),
        .rword (rword)
    );

endmodule

// File: rtl/regbus_lane_checker.sv
module regbus_lane_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ack,
    input logic [15:0]       req_rdata
);

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    assert_rdata_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_ack |-> req_rdata == 16'h0000);

    assert_write_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (req_ack && req_write) |-> req_rdata == 16'h0000);

    assert_unsup_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (req_ack && (req_size == 2'b00 || req_size == 2'b11)) |-> req_rdata == 16'h0000);

    assert_ack_after_req_R5: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> $past(req_valid));

    assert_split_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (req_ack && req_size == 2'b10 && req_addr[0])
            |-> ($past(req_valid, 3) && !$past(req_ack, 1) && !$past(req_ack, 2)));

endmodule

bind regbus_lane_adapter regbus_lane_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_ack   (req_ack),
    .req_rdata (req_rdata)
);

// File: tb/test_regbus_lane_adapter.sv
`timescale 1ns/1ps
module test_regbus_lane_adapter;

    localparam int NREG   = 8;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size  = 2'b00;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [15:0]       req_wdata = '0;
    logic              req_ack;
    logic [15:0]       req_rdata;

    int checks   = 0;
    int failures = 0;
    logic [15:0] model [NREG];

    always #10 clk = ~clk;

    regbus_lane_adapter #(.NUM_REGS(NREG)) i_regbus_lane_adapter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input int addr,
                          input logic [15:0] wd, output logic [15:0] rd, output int n);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = sz;
        req_addr  = ADDR_W'(addr);
        req_wdata = wd;
        n = 0;
        rd = '0;
        while (n < 20) begin
            @(negedge clk);
            n++;
            if (req_ack) begin
                rd = req_rdata;
                break;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 ack pulse", {15'h0, req_ack}, 16'h0);
        chk("R10 rdata idle", req_rdata, 16'h0);
    endtask

    task automatic verify_all(input string req);
        logic [15:0] rd;
        int n;
        for (int i = 0; i < NREG; i++) begin
            access(1'b0, 2'b10, 2 * i, 16'h0, rd, n);
            chk(req, rd, model[i]);
        end
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int n;
        logic [15:0] w;
        for (int i = 0; i < NREG; i++) model[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R1 ack reset", {15'h0, req_ack}, 16'h0);
        chk("R1 rdata reset", req_rdata, 16'h0);
        rst = 1'b0;
        verify_all("R1 location reset");

        // R5: aligned writes then reads, latency 2
        for (int i = 0; i < NREG; i++) begin
            w = 16'h1357 ^ 16'(i * 16'h0923);
            access(1'b1, 2'b10, 2 * i, w, rd, n);
            model[i] = w;
            chk("R11 write rdata", rd, 16'h0);
            chk("R5 write latency", 16'(n), 16'd2);
        end
        for (int i = 0; i < NREG; i++) begin
            access(1'b0, 2'b10, 2 * i, 16'h0, rd, n);
            chk("R5 aligned read", rd, model[i]);
            chk("R5 read latency", 16'(n), 16'd2);
        end

        // R2/R3: byte writes at every address, R4 byte reads both addresses
        for (int a = 0; a < 2 * NREG; a++) begin
            w = 16'(16'hC3A5 + a * 16'h1111);
            access(1'b1, 2'b01, a, w, rd, n);
            if (a % 2 == 0) model[a / 2][15:8] = w[15:8];
            else            model[a / 2][7:0]  = w[7:0];
            access(1'b0, 2'b01, a, 16'h0, rd, n);
            chk((a % 2 == 0) ? "R2 even byte write" : "R3 odd byte write", rd, model[a / 2]);
            access(1'b0, 2'b01, a ^ 1, 16'h0, rd, n);
            chk("R4 byte read full word", rd, model[a / 2]);
        end
        verify_all("R2 R3 neighbours kept");

        // R6/R8: split writes at every odd address
        for (int i = 0; i < NREG; i++) begin
            w = 16'(16'h5AF0 + i * 16'h0F1E);
            access(1'b1, 2'b10, 2 * i + 1, w, rd, n);
            model[i][7:0] = w[15:8];
            model[(i + 1) % NREG][15:8] = w[7:0];
            chk("R6 split write latency", 16'(n), 16'd3);
            chk("R11 split write rdata", rd, 16'h0);
            verify_all((i == NREG - 1) ? "R8 wrap write" : "R6 split write");
        end

        // R7/R8: split reads at every odd address
        for (int i = 0; i < NREG; i++) begin
            access(1'b0, 2'b10, 2 * i + 1, 16'h0, rd, n);
            chk((i == NREG - 1) ? "R8 wrap read" : "R7 split read", rd,
                {model[i][7:0], model[(i + 1) % NREG][15:8]});
            chk("R7 split read latency", 16'(n), 16'd3);
        end

        // R9: unsupported sizes, both directions and both parities
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 2 * NREG; a += 3) begin
                access(1'b1, (s == 0) ? 2'b00 : 2'b11, a, 16'hFFFF, rd, n);
                chk("R9 unsupported write latency", 16'(n), 16'd2);
                access(1'b0, (s == 0) ? 2'b00 : 2'b11, a, 16'h0, rd, n);
                chk("R9 unsupported read zero", rd, 16'h0);
            end
        end
        verify_all("R9 no change");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule